// File: doc/BRIEF.md
# Message-Object Receive Acceptance Filter

This block decides which of a small set of message objects takes a received CAN frame header. Each object is armed through a configuration port. Arming sets the object's enable, its direction, its frame format and whether it belongs to the receive buffer. It also loads a 32-bit header tag and a 32-bit header mask. When a frame strobe arrives, every enabled receive object compares the header against its tag, but only on the bits its mask selects. One object is chosen to accept the frame.

The accepting object is then closed. Its received flag goes high and it latches the free-running timer value as its timestamp. The object stays closed until it is armed again. An acknowledge port clears an object's received and overrun flags.

Objects marked as buffer members form one receive group. The group does not have to be made of adjacent objects. A frame that any member's filter accepts goes to the lowest-numbered member that is still open. The group therefore fills up one frame at a time.

Top module: `msgobj_accept`

## Requirements
- R1: After reset no object is enabled, `hit_o` is low, and all received flags, overrun flags and timestamps read zero.
- R2: Headers are laid out as {identifier[28:0], RTR, reserved, IDE}, with the identifier in bits 31:3, RTR in bit 2, reserved in bit 1 and IDE in bit 0. An object's filter matches when the header equals its tag on every bit whose mask bit is 1. Bits with mask 0 are ignored.
- R3: An object in standard format (`cfg_ext`=0) compares only identifier bits 28:18 (header bits 31:21) and the three flag bits. Identifier bits 17:0 have no effect on the match.
- R4: Objects that are disabled, or set to transmit (`cfg_rx`=0), never accept a frame.
- R5: When several eligible objects match one frame, the lowest-numbered object accepts it.
- R6: An open receive object with `cfg_buf`=1 is eligible when the filter of any receive-direction buffer member matches. That member may be open or closed. Eligible objects are then resolved as in R5.
- R7: One cycle after a strobe with an eligible object, `hit_o` pulses and `win_o` gives the accepting object. That object's received flag is set and the object is closed, so a repeat of the frame is not taken by it.
- R8: If the accepting object's received flag was already set (it was re-armed without an acknowledge), its overrun flag is set.
- R9: The accepting object's timestamp holds the value `timer_in` had on the strobe cycle.
- R10: A strobe with no eligible object leaves `hit_o` low and changes no flag or timestamp.
- R11: An acknowledge of object n clears its received and overrun flags one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Arm (configure) the object selected by `cfg_idx` |
| cfg_idx | input | 2 | Object to arm |
| cfg_en | input | 1 | Open the object for acceptance |
| cfg_rx | input | 1 | 1 = receive object, 0 = transmit object |
| cfg_ext | input | 1 | 1 = extended 29-bit format, 0 = standard 11-bit format |
| cfg_buf | input | 1 | Object is a member of the receive buffer group |
| cfg_tag | input | 32 | Header tag {id, RTR, reserved, IDE} |
| cfg_mask | input | 32 | Header compare mask, 1 = compare the bit |
| ack_we | input | 1 | Acknowledge the object selected by `ack_idx` |
| ack_idx | input | 2 | Object to acknowledge |
| fr_valid | input | 1 | Received header strobe |
| fr_id | input | 29 | Received identifier |
| fr_rtr | input | 1 | Received RTR bit |
| fr_rb | input | 1 | Received reserved bit |
| fr_ide | input | 1 | Received IDE bit |
| timer_in | input | 16 | Free-running timestamp timer |
| hit_o | output | 1 | One-cycle pulse: a frame was accepted |
| win_o | output | 2 | Index of the accepting object |
| rxok_o | output | 4 | Per-object received flags |
| ovr_o | output | 4 | Per-object overrun flags |
| stamps_o | output | 64 | Per-object timestamps; object n in bits [16n+15:16n] |

## Verification
Directed frames are sent first, with these purposes:
- A frame that differs only in RTR separates a full-header compare from an identifier-only compare.
- A standard-format frame with arbitrary low identifier bits shows that those bits are ignored.
- Pairs of overlapping filters, one of which sits on a transmit object, separate direction gating from priority.
- A two-member buffer whose members are not adjacent and whose filters differ receives, in order, a frame for the higher member's filter and then one for the lower member's filter. This shows that the group shares its filters and fills from the lowest open member.

After that, random arming, acknowledges and frames are mixed. The frames are built from armed tags with random bit flips, so matches, near-misses, re-arms that overrun and multi-object ties all occur.

// File: rtl/msgobj_accept.sv
module msgobj_accept #(
  parameter int NOBJ = 4,
  parameter int IDW  = 29,
  parameter int SIDW = 11,
  parameter int TSW  = 16,
  localparam int IW  = $clog2(NOBJ),
  localparam int HW  = IDW + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_idx,
  input  logic                cfg_en,
  input  logic                cfg_rx,
  input  logic                cfg_ext,
  input  logic                cfg_buf,
  input  logic [HW-1:0]       cfg_tag,
  input  logic [HW-1:0]       cfg_mask,
  input  logic                ack_we,
  input  logic [IW-1:0]       ack_idx,
  input  logic                fr_valid,
  input  logic [IDW-1:0]      fr_id,
  input  logic                fr_rtr,
  input  logic                fr_rb,
  input  logic                fr_ide,
  input  logic [TSW-1:0]      timer_in,
  output logic                hit_o,
  output logic [IW-1:0]       win_o,
  output logic [NOBJ-1:0]     rxok_o,
  output logic [NOBJ-1:0]     ovr_o,
  output logic [NOBJ*TSW-1:0] stamps_o
);
  localparam logic [HW-1:0] STD_MASK = {{SIDW{1'b1}}, {(IDW-SIDW){1'b0}}, 3'b111};

  logic [NOBJ-1:0] en_q, rx_q, ext_q, buf_q, match, elig;
  logic [HW-1:0]   tag_q  [NOBJ];
  logic [HW-1:0]   mask_q [NOBJ];
  logic [TSW-1:0]  stamp_q[NOBJ];
  logic [IW-1:0]   win;
  logic            any, grp_hit;

  wire [HW-1:0] hdr = {fr_id, fr_rtr, fr_rb, fr_ide};

  assign grp_hit = |(match & rx_q & buf_q);
  assign elig    = en_q & rx_q & ((buf_q & {NOBJ{grp_hit}}) | (~buf_q & match));
  assign any     = |elig;

  always_comb begin
    win = '0;
    for (int i = NOBJ - 1; i >= 0; i--)
      if (elig[i]) win = IW'(i);
  end

  wire take = fr_valid & any;

  for (genvar i = 0; i < NOBJ; i++) begin : g_obj
    wire [HW-1:0] eff = mask_q[i] & (ext_q[i] ? {HW{1'b1}} : STD_MASK);
    wire acked = ack_we && (ack_idx == IW'(i));
    wire won   = take && (win == IW'(i));
    wire armed = cfg_we && (cfg_idx == IW'(i));

    assign match[i] = ((hdr ^ tag_q[i]) & eff) == '0;
    assign stamps_o[i*TSW +: TSW] = stamp_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]    <= 1'b0;
        rx_q[i]    <= 1'b0;
        ext_q[i]   <= 1'b0;
        buf_q[i]   <= 1'b0;
        tag_q[i]   <= '0;
        mask_q[i]  <= '0;
        stamp_q[i] <= '0;
        rxok_o[i]  <= 1'b0;
        ovr_o[i]   <= 1'b0;
      end else begin
        if (acked) begin
          rxok_o[i] <= 1'b0;
          ovr_o[i]  <= 1'b0;
        end
        if (won) begin
          en_q[i]    <= 1'b0;
          rxok_o[i]  <= 1'b1;
          ovr_o[i]   <= (ovr_o[i] | rxok_o[i]) & ~acked;
          stamp_q[i] <= timer_in;
        end
        if (armed) begin
          en_q[i]   <= cfg_en;
          rx_q[i]   <= cfg_rx;
          ext_q[i]  <= cfg_ext;
          buf_q[i]  <= cfg_buf;
          tag_q[i]  <= cfg_tag;
          mask_q[i] <= cfg_mask;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o <= 1'b0;
      win_o <= '0;
    end else begin
      hit_o <= take;
      if (take) win_o <= win;
    end
  end
endmodule

module msgobj_accept_chk #(
  parameter int NOBJ = 4,
  parameter int TSW  = 16,
  localparam int IW  = $clog2(NOBJ)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_we,
  input logic [IW-1:0]       ack_idx,
  input logic                fr_valid,
  input logic [TSW-1:0]      timer_in,
  input logic                hit_o,
  input logic [IW-1:0]       win_o,
  input logic [NOBJ-1:0]     rxok_o,
  input logic [NOBJ-1:0]     ovr_o,
  input logic [NOBJ*TSW-1:0] stamps_o
);
  // R7
  rxok_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> rxok_o[win_o]);

  // R10
  hit_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(fr_valid));

  // R9
  stamp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> stamps_o[win_o*TSW +: TSW] == $past(timer_in));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !$past(ack_we) && (($past(rxok_o) & (NOBJ'(1) << win_o)) != '0))
      |-> ovr_o[win_o]);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_we) && !(hit_o && win_o == $past(ack_idx)))
      |-> (!rxok_o[$past(ack_idx)] && !ovr_o[$past(ack_idx)]));

  // R8
  overrun_implies_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o & ~rxok_o) == '0);
endmodule

bind msgobj_accept msgobj_accept_chk #(.NOBJ(NOBJ), .TSW(TSW)) u_chk (.*);

// File: tb/msgobj_accept_bench.sv
module msgobj_accept_bench;
  localparam int N = 4, IDW = 29, HW = 32, TSW = 16;
  localparam logic [HW-1:0] STDM = {11'h7FF, 18'h0, 3'b111};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_rx = 0, cfg_ext = 0, cfg_buf = 0;
  logic [1:0] cfg_idx = 0, ack_idx = 0;
  logic [HW-1:0] cfg_tag = 0, cfg_mask = 0;
  logic ack_we = 0, fr_valid = 0, fr_rtr = 0, fr_rb = 0, fr_ide = 0;
  logic [IDW-1:0] fr_id = 0;
  logic [TSW-1:0] timer_in = 0;
  logic hit_o;
  logic [1:0] win_o;
  logic [N-1:0] rxok_o, ovr_o;
  logic [N*TSW-1:0] stamps_o;

  msgobj_accept u_msgobj_accept (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_en[N], m_rx[N], m_ext[N], m_buf[N], m_ok[N], m_ovr[N];
  logic [HW-1:0] m_tag[N], m_mask[N];
  logic [TSW-1:0] m_stamp[N];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    timer_in = timer_in + 1;
  endtask

  function automatic bit fmatch(int i, logic [HW-1:0] h);
    logic [HW-1:0] e = m_mask[i] & (m_ext[i] ? '1 : STDM);
    return ((h ^ m_tag[i]) & e) == 0;
  endfunction

  function automatic int predict(logic [HW-1:0] h);
    bit grp = 0;
    for (int i = 0; i < N; i++) if (m_rx[i] && m_buf[i] && fmatch(i, h)) grp = 1;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_rx[i] && (m_buf[i] ? grp : fmatch(i, h))) return i;
    return -1;
  endfunction

  task automatic arm(int i, bit en, bit rx, bit ext, bit bf, logic [HW-1:0] tag, logic [HW-1:0] mask);
    cfg_we = 1; cfg_idx = 2'(i); cfg_en = en; cfg_rx = rx; cfg_ext = ext; cfg_buf = bf;
    cfg_tag = tag; cfg_mask = mask;
    adv();
    cfg_we = 0;
    m_en[i] = en; m_rx[i] = rx; m_ext[i] = ext; m_buf[i] = bf; m_tag[i] = tag; m_mask[i] = mask;
  endtask

  task automatic ack(int i);
    ack_we = 1; ack_idx = 2'(i);
    adv();
    ack_we = 0;
    m_ok[i] = 0; m_ovr[i] = 0;
    chk(!rxok_o[i] && !ovr_o[i], "R11 ack clears flags", {rxok_o[i], ovr_o[i]}, 0);
  endtask

  task automatic send(logic [HW-1:0] h, string req);
    int w = predict(h);
    logic [TSW-1:0] ts = timer_in;
    logic [N-1:0] ok_v, ovr_v;
    {fr_id, fr_rtr, fr_rb, fr_ide} = h;
    fr_valid = 1;
    adv();
    fr_valid = 0;
    chk(hit_o == (w >= 0), {req, " hit"}, hit_o, w >= 0);
    if (w >= 0) begin
      chk(win_o == 2'(w), {req, " R5 winner"}, win_o, w);
      m_ovr[w] = m_ovr[w] | m_ok[w];
      m_ok[w] = 1; m_en[w] = 0; m_stamp[w] = ts;
      chk(stamps_o[w*TSW +: TSW] == ts, {req, " R9 stamp"}, stamps_o[w*TSW +: TSW], ts);
    end
    for (int i = 0; i < N; i++) begin ok_v[i] = m_ok[i]; ovr_v[i] = m_ovr[i]; end
    chk(rxok_o == ok_v, {req, " R7 rxok"}, rxok_o, ok_v);
    chk(ovr_o == ovr_v, {req, " R8 ovr"}, ovr_o, ovr_v);
  endtask

  function automatic logic [HW-1:0] hd(logic [IDW-1:0] id, bit rtr, bit rb, bit ide);
    return {id, rtr, rb, ide};
  endfunction

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [HW-1:0] a, b;
    int unused_seed = $urandom(32'h1F2E);
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_rx[i] = 0; m_ext[i] = 0; m_buf[i] = 0; m_ok[i] = 0; m_ovr[i] = 0;
      m_tag[i] = 0; m_mask[i] = 0; m_stamp[i] = 0;
    end
    repeat (3) adv();
    chk(!hit_o && rxok_o == 0 && ovr_o == 0 && stamps_o == 0, "R1 reset state",
        {hit_o, rxok_o, ovr_o}, 0);
    rst_n = 1;
    adv();

    a = hd({11'h123, 18'h0}, 0, 0, 0);
    arm(1, 1, 1, 0, 0, a, '1);
    send(hd({11'h123, 18'h0}, 1, 0, 0), "R2 rtr mismatch");
    send(hd({11'h123, 18'h2A5C3}, 0, 0, 0), "R3 std low bits ignored");
    send(hd({11'h123, 18'h0}, 0, 0, 0), "R7 closed after accept");

    b = hd(29'h0ABCDEF1, 0, 0, 1);
    arm(0, 1, 0, 1, 0, b, '1);
    arm(2, 1, 1, 1, 0, b, '1);
    send(b, "R4 transmit skipped");
    send(b ^ 32'h8, "R2 ext low bit differs");

    arm(1, 1, 1, 1, 0, b, '1);
    arm(3, 1, 1, 1, 0, b, '1);
    send(b, "R5 lowest wins");
    arm(1, 1, 1, 1, 0, b, '1);
    send(b, "R8 rearm overrun");
    ack(1);
    ack(2);
    ack(3);

    arm(0, 1, 1, 1, 1, a, '1);
    arm(3, 1, 1, 1, 1, b, '1);
    arm(1, 0, 1, 1, 0, 0, 0);
    arm(2, 0, 1, 1, 0, 0, 0);
    send(b, "R6 buffer lowest member");
    send(a, "R6 buffer next member");
    send(a, "R6 buffer full");
    send(hd(29'h1, 1, 1, 1), "R10 no hit");

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      int i = $urandom_range(0, N - 1);
      if (op < 3)
        arm(i, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
            $urandom_range(0, 3) == 0, $urandom, $urandom & $urandom);
      else if (op < 4)
        ack(i);
      else begin
        logic [HW-1:0] h = m_tag[i];
        if ($urandom_range(0, 1)) h = h ^ (32'h1 << $urandom_range(0, 31));
        send(h, "R2 random frame");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule